// File: doc/BRIEF.md
# Trace timestamp request generator

This block tells a trace unit when to insert a timestamp into its output stream. Two sources can ask for one. The first is a programmable interval counter. It expires once every 2^level clock cycles. The second is a byte counter. It counts trace bytes and marks a synchronisation point after each complete block of 4096 bytes. Every synchronisation point raises a timestamp request, and interval expiries add more requests on top of those. The gap between two timestamps therefore never exceeds one synchronisation block.

Software loads a 4-bit level through a load strobe. Level codes 0 to 14 select intervals from 1 to 16384 cycles. Code 15 switches the interval counter off and releases it. The global enable suppresses every timestamp request but leaves synchronisation requests running. The byte strobe is a plain one-cycle marker with no handshake. The block can never refuse a byte, so there is no back-pressure.

Top module: `trace_ts_request_gen`

## Requirements
- R1: During and after reset, `ts_req` and `sync_req` are 0 and `ival_active` is 0, because reset selects level code 15. The byte count and the interval count both restart from zero.
- R2: For a loaded level L from 0 to 14, `ts_req` is high in the cycle that starts 2^L clock edges after the load edge, and again every 2^L edges after that. This holds while `ts_en` is 1 and no synchronisation request intervenes.
- R3: Level 0 makes `ts_req` high in every cycle after the load cycle. Level 10 makes it high once every 1024 cycles.
- R4: Loading level 15 drives `ival_active` to 0 and stops all interval-driven timestamp requests. Loading any other level drives `ival_active` to 1 from the cycle after the load edge.
- R5: `sync_req` is a one-cycle pulse in the cycle after the clock edge that samples the 4096th, 8192nd and every further multiple of 4096 `trace_byte_stb` pulse since reset. The 12-bit byte count wraps with no gap.
- R6: While `ts_en` is 1, every `sync_req` pulse comes with `ts_req` in the same cycle, whatever the level.
- R7: While `ts_en` is 0, `ts_req` stays 0, but `sync_req` is still issued. The interval counter keeps running, so its phase is unchanged when the enable returns.
- R8: An interval expiry and a synchronisation point can fall on the same edge. They then produce a single `ts_req` pulse, one cycle wide, with no extra pulse in the next cycle.
- R9: A `cfg_load` pulse restarts the interval from the load edge with the new level and drops the old phase. No interval-driven request is issued on the load edge itself.
- R10: Loading a level leaves the byte count untouched. Byte strobes leave the interval count untouched.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; all state changes on the rising edge |
| rst_n | input | 1 | Synchronous reset, active low |
| ts_en | input | 1 | Global timestamp enable |
| ival_level | input | 4 | Interval level code, sampled when `cfg_load` is high; 15 = counter off |
| cfg_load | input | 1 | One-cycle strobe that loads `ival_level` and restarts the interval |
| trace_byte_stb | input | 1 | One-cycle marker for each trace byte written |
| ts_req | output | 1 | Timestamp request pulse |
| sync_req | output | 1 | Synchronisation request pulse |
| ival_active | output | 1 | High while the interval counter is in use |

## Verification
A wrong value in the interval counter moves the phase of every later `ts_req` pulse. The error shows within 2^L cycles and stays until the next `cfg_load` or reset. A wrong byte count shifts every later `sync_req` by a fixed number of strobes. It only becomes visible at the next block boundary, which can be up to 4096 strobes later. For that reason the bench tracks byte totals across level changes and reset. A wrong merge of the two request sources shows at once as a missing or doubled `ts_req` on the edges where an expiry and a synchronisation point meet.

// File: rtl/trace_ts_pkg.sv
package trace_ts_pkg;
  localparam int TS_LVL_W_DEF  = 4;
  localparam int TS_BYTE_W_DEF = 12;

  // sources that can ask for a timestamp in a given cycle
  typedef struct packed {
    logic ival_hit;
    logic sync_hit;
  } ts_src_t;
endpackage

// File: rtl/ts_interval_ctr.sv
module ts_interval_ctr #(
  parameter int LVL_W = trace_ts_pkg::TS_LVL_W_DEF
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             cfg_load,
  input  logic [LVL_W-1:0] level_in,
  output logic             expiry_o,
  output logic             active_o
);
  // the highest code switches the counter off, so the top usable level is 2^LVL_W-2
  localparam int CNT_W = (1 << LVL_W) - 2;
  localparam logic [LVL_W-1:0] LVL_OFF = '1;

  logic [LVL_W-1:0] level_q;
  logic [CNT_W-1:0] cnt_q;

  function automatic logic [CNT_W-1:0] reload_of(input logic [LVL_W-1:0] lvl);
    logic [CNT_W:0] pow;
    logic [CNT_W:0] val;
    pow = (CNT_W+1)'(1) << lvl;
    val = pow - 1'b1;
    return val[CNT_W-1:0];
  endfunction

  assign active_o = (level_q != LVL_OFF);
  assign expiry_o = active_o && !cfg_load && (cnt_q == '0);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      level_q <= LVL_OFF;
      cnt_q   <= '0;
    end else if (cfg_load) begin
      level_q <= level_in;
      cnt_q   <= (level_in == LVL_OFF) ? '0 : reload_of(level_in);
    end else if (active_o) begin
      if (cnt_q == '0) cnt_q <= reload_of(level_q);
      else             cnt_q <= cnt_q - 1'b1;
    end
  end

  p_countdown_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (active_o && !cfg_load && cnt_q != '0) |=> (cnt_q == $past(cnt_q) - 1'b1));

  p_off_hold_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (!active_o && !cfg_load) |=> ($stable(cnt_q) && !expiry_o));
endmodule

// File: rtl/ts_sync_ctr.sv
module ts_sync_ctr #(
  parameter int BYTE_W = trace_ts_pkg::TS_BYTE_W_DEF
) (
  input  logic clk,
  input  logic rst_n,
  input  logic byte_stb,
  output logic sync_hit_o
);
  localparam logic [BYTE_W-1:0] LAST_BYTE = '1;

  logic [BYTE_W-1:0] bytes_q;

  // the strobe that completes a block raises the hit
  assign sync_hit_o = byte_stb && (bytes_q == LAST_BYTE);

  always_ff @(posedge clk) begin
    if (!rst_n)        bytes_q <= '0;
    else if (byte_stb) bytes_q <= bytes_q + 1'b1;
  end

  p_byte_step_r5: assert property (@(posedge clk) disable iff (!rst_n)
    byte_stb |=> (bytes_q == $past(bytes_q) + 1'b1));

  p_byte_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
    !byte_stb |=> $stable(bytes_q));
endmodule

// File: rtl/ts_req_merge.sv
module ts_req_merge
  import trace_ts_pkg::*;
(
  input  logic    clk,
  input  logic    rst_n,
  input  logic    ts_en,
  input  ts_src_t src,
  output logic    ts_req_o,
  output logic    sync_req_o
);
  logic any_src;
  assign any_src = src.ival_hit | src.sync_hit;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ts_req_o   <= 1'b0;
      sync_req_o <= 1'b0;
    end else begin
      ts_req_o   <= ts_en && any_src;
      sync_req_o <= src.sync_hit;
    end
  end

  p_no_ts_disabled_r7: assert property (@(posedge clk) disable iff (!rst_n)
    !ts_en |=> !ts_req_o);

  p_sync_gives_ts_r6: assert property (@(posedge clk) disable iff (!rst_n)
    ts_en |=> (sync_req_o |-> ts_req_o));

  p_sync_single_r5: assert property (@(posedge clk) disable iff (!rst_n)
    sync_req_o |=> !sync_req_o);
endmodule

// File: rtl/trace_ts_request_gen.sv
module trace_ts_request_gen
  import trace_ts_pkg::*;
#(
  parameter int LVL_W  = TS_LVL_W_DEF,
  parameter int BYTE_W = TS_BYTE_W_DEF
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             ts_en,
  input  logic [LVL_W-1:0] ival_level,
  input  logic             cfg_load,
  input  logic             trace_byte_stb,
  output logic             ts_req,
  output logic             sync_req,
  output logic             ival_active
);
  ts_src_t src;

  ts_interval_ctr #(.LVL_W(LVL_W)) u_ival (
    .clk      (clk),
    .rst_n    (rst_n),
    .cfg_load (cfg_load),
    .level_in (ival_level),
    .expiry_o (src.ival_hit),
    .active_o (ival_active)
  );

  ts_sync_ctr #(.BYTE_W(BYTE_W)) u_sync (
    .clk        (clk),
    .rst_n      (rst_n),
    .byte_stb   (trace_byte_stb),
    .sync_hit_o (src.sync_hit)
  );

  ts_req_merge u_merge (
    .clk        (clk),
    .rst_n      (rst_n),
    .ts_en      (ts_en),
    .src        (src),
    .ts_req_o   (ts_req),
    .sync_req_o (sync_req)
  );

  // with the counter idle, a timestamp can only come from a sync point
  p_idle_only_sync_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (!ival_active && !cfg_load && !src.sync_hit) |=> !ts_req);

  p_load_no_expiry_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg_load && !src.sync_hit) |=> !ts_req);
endmodule

// File: tb/trace_ts_request_gen_tb_top.sv
module trace_ts_request_gen_tb_top;
  logic clk = 1'b0;
  always #5 clk = ~clk;

  logic       rst_n, ts_en, cfg_load, trace_byte_stb;
  logic [3:0] ival_level;
  logic       ts_req, sync_req, ival_active;

  trace_ts_request_gen dut_i (
    .clk(clk), .rst_n(rst_n), .ts_en(ts_en), .ival_level(ival_level),
    .cfg_load(cfg_load), .trace_byte_stb(trace_byte_stb),
    .ts_req(ts_req), .sync_req(sync_req), .ival_active(ival_active)
  );

  int n_cmp = 0;
  int n_bad = 0;
  // reference model state, built from the requirements
  int m_level = 15;
  int m_phase = 0;
  int m_bytes = 0;
  int err_ts = 0, err_sync = 0, err_act = 0;
  int act_ts = 0, exp_ts = 0;
  bit done = 1'b0;

  typedef struct packed {
    logic [3:0]  lvl;
    logic        en;
    logic [1:0]  bpat;   // 0 none, 1 every cycle, 2 alternate cycles
    logic [15:0] cyc;
  } vec_t;

  localparam int NV = 9;
  localparam vec_t VECS [NV] = '{
    '{4'd0,  1'b1, 2'd0, 16'd10},
    '{4'd1,  1'b1, 2'd0, 16'd20},
    '{4'd3,  1'b1, 2'd2, 16'd60},
    '{4'd10, 1'b1, 2'd0, 16'd3100},
    '{4'd15, 1'b1, 2'd1, 16'd4200},
    '{4'd4,  1'b0, 2'd1, 16'd4200},
    '{4'd2,  1'b1, 2'd1, 16'd4200},
    '{4'd14, 1'b1, 2'd0, 16'd16400},
    '{4'd5,  1'b1, 2'd2, 16'd200}
  };

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    n_cmp++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic summary();
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
  endtask

  // called just after a falling edge; returns just after the next falling edge
  task automatic tick(input bit ld, input logic [3:0] lv, input bit bv);
    bit e_exp, e_sync, e_ts;
    cfg_load = ld; ival_level = lv; trace_byte_stb = bv;
    e_exp = 1'b0;
    @(posedge clk);
    if (ld) begin
      m_level = lv; m_phase = 0;
    end else begin
      m_phase++;
      if (m_level != 15) e_exp = (m_phase % (1 << m_level)) == 0;
    end
    if (bv) m_bytes++;
    e_sync = bv && (m_bytes % 4096 == 0);
    e_ts = ts_en && (e_exp || e_sync);
    #4;
    act_ts = int'(ts_req); exp_ts = int'(e_ts);
    if (ts_req !== e_ts) err_ts++;
    if (sync_req !== e_sync) err_sync++;
    if (ival_active !== (m_level != 15)) err_act++;
    @(negedge clk);
    cfg_load = 1'b0; trace_byte_stb = 1'b0;
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst_n = 1'b0;
    @(posedge clk); #4;
    check(ts_req === 1'b0 && sync_req === 1'b0, "R1 requests in reset", int'(ts_req | sync_req), 0);
    @(negedge clk);
    rst_n = 1'b1;
    m_level = 15; m_phase = 0; m_bytes = 0;
    #1;
    check(ival_active === 1'b0, "R1 ival_active after reset", int'(ival_active), 0);
  endtask

  initial begin
    #(200000 * 10);
    if (!done) begin
      n_cmp++; n_bad++;
      $display("FAIL watchdog expired actual=1 expected=0");
      summary();
      $finish;
    end
  end

  initial begin
    string tag;
    rst_n = 1'b0; ts_en = 1'b0; cfg_load = 1'b0; trace_byte_stb = 1'b0; ival_level = 4'd0;
    repeat (3) @(posedge clk);
    #4;
    check(ts_req === 1'b0 && sync_req === 1'b0 && ival_active === 1'b0,
          "R1 reset state", int'({ts_req, sync_req, ival_active}), 0);
    @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    check(ival_active === 1'b0, "R1 ival_active idle", int'(ival_active), 0);

    // table walk
    for (int v = 0; v < NV; v++) begin
      ts_en = VECS[v].en;
      err_ts = 0; err_sync = 0; err_act = 0;
      tick(1'b1, VECS[v].lvl, 1'b0);
      for (int c = 0; c < int'(VECS[v].cyc); c++) begin
        bit bv;
        bv = (VECS[v].bpat == 2'd1) ? 1'b1 : (VECS[v].bpat == 2'd2) ? c[0] : 1'b0;
        tick(1'b0, VECS[v].lvl, bv);
      end
      if (!VECS[v].en)             tag = "R7 ts_req gated";
      else if (VECS[v].lvl == 15)  tag = "R4 ts_req with counter off";
      else if (VECS[v].lvl == 0 || VECS[v].lvl == 10) tag = "R3 ts_req spacing";
      else                         tag = "R2 ts_req spacing";
      check(err_ts == 0, tag, err_ts, 0);
      check(err_sync == 0, "R5 sync_req placement", err_sync, 0);
      check(err_act == 0, "R4 ival_active", err_act, 0);
    end

    // coincident expiry and sync point
    do_reset();
    ts_en = 1'b1;
    err_ts = 0; err_sync = 0;
    tick(1'b1, 4'd2, 1'b0);
    for (int c = 0; c < 4095; c++) tick(1'b0, 4'd2, 1'b1);
    tick(1'b0, 4'd2, 1'b1);
    check(ts_req === 1'b1 && sync_req === 1'b1, "R8 merged pulse present", act_ts, 1);
    check(ts_req === 1'b1, "R6 sync raises ts_req", act_ts, 1);
    tick(1'b0, 4'd2, 1'b0);
    check(ts_req === 1'b0, "R8 no second pulse", act_ts, 0);
    check(err_ts == 0 && err_sync == 0, "R8 merged sequence", err_ts + err_sync, 0);

    // reload mid-period
    err_ts = 0;
    tick(1'b1, 4'd3, 1'b0);
    repeat (5) tick(1'b0, 4'd3, 1'b0);
    tick(1'b1, 4'd1, 1'b0);
    check(ts_req === 1'b0, "R9 no request on load edge", act_ts, 0);
    tick(1'b0, 4'd1, 1'b0);
    check(ts_req === 1'b0, "R9 restart phase 1", act_ts, 0);
    tick(1'b0, 4'd1, 1'b0);
    check(ts_req === 1'b1, "R9 first pulse after reload", act_ts, 1);
    check(err_ts == 0, "R9 reload sequence", err_ts, 0);

    // byte count survives level loads
    err_sync = 0;
    for (int c = 0; c < 2000; c++) tick(1'b0, 4'd1, 1'b1);
    tick(1'b1, 4'd15, 1'b0);
    for (int c = 0; c < 2095; c++) tick(1'b0, 4'd15, 1'b1);
    check(sync_req === 1'b0, "R10 no early sync", int'(sync_req), 0);
    tick(1'b0, 4'd15, 1'b1);
    check(sync_req === 1'b1, "R10 sync after load", int'(sync_req), 1);
    check(err_sync == 0, "R10 byte count kept", err_sync, 0);

    // sync still issued with enable low
    ts_en = 1'b0;
    err_ts = 0; err_sync = 0;
    for (int c = 0; c < 4096; c++) tick(1'b0, 4'd15, 1'b1);
    check(sync_req === 1'b1 && ts_req === 1'b0, "R7 sync while disabled",
          int'({sync_req, ts_req}), 2);
    check(err_ts == 0 && err_sync == 0, "R7 disabled run", err_ts + err_sync, 0);

    done = 1'b1;
    summary();
    $finish;
  end
endmodule